// File: doc/BRIEF.md
# Banked Host Register Window

This block gives a host a 16-bit register window of eight halfword slots at even byte offsets 0x0 through 0xE. The top slot (offset 0xE) always holds a bank-select register. The other seven slots are routed to one of several register banks, chosen by the bank number held there. The block decodes each host read and write, applies byte enables, and steers the access to the selected bank. Accesses to bank numbers or slots that hold nothing read as zero and are dropped when written.

Three bank slots are special. A read-only identification word carries a fixed signature and a revision code. A statistics word packs four 4-bit event counters that clear when they are read. A status word carries a sticky rollover flag for those counters. A receive-control word has a soft-reset bit that, while set, holds every other piece of register state at its reset value. All other implemented slots are plain read/write storage.

Read data is combinational from the current address and state, and is valid in the same cycle as the read strobe. Side effects of a read, such as clearing the counters, take effect at the clock edge that ends that cycle.

Top module: `bankwin_regs`

## Requirements
- R1: The bank-select register answers at offset 0xE whatever bank is selected, for both reads and writes.
- R2: A bank-select read returns 0x33 in bits 15:8, zero in bits 7:3 and the bank number in bits 2:0. Writing 0xFFFB and reading back gives 0x3303, because writes to bits 15:3 are ignored.
- R3: Bank 3, offset 0xA reads 0x3391: signature 0x33 in the upper byte and revision code 0x91 in the lower byte. Writes to it have no effect.
- R4: Bank 0, offset 0x6 reads four event counts. Input evt_inc[3] (excessive deferral) counts in bits 15:12, evt_inc[2] (deferral) in bits 11:8, evt_inc[1] (multiple collision) in bits 7:4 and evt_inc[0] (single collision) in bits 3:0. Each high cycle of an input adds one.
- R5: A read of the counter word returns the current counts and clears all four counters at that edge. An increment in the same cycle as the read is applied after the clear, so that counter then holds 1.
- R6: An increment while a counter holds 0xF is a rollover. The counter stays at 0xF, and bit 12 of the bank 0 status word at offset 0x2 becomes 1; its other bits read 0. The flag stays set until the counter word is read, which clears it.
- R7: Bit 15 of the bank 0 receive-control word at offset 0x4 is a soft reset. While it is 1, the bank number is forced to 0, the storage slots, counters and rollover flag are held at zero, and all writes except to the receive-control word are ignored. Event inputs are also ignored. Writing 0 to the bit releases the hold.
- R8: With a bank number of 4 to 7 selected, every offset except 0xE reads 0 and writes to them have no effect.
- R9: All other slots of banks 0 to 3 are independent 16-bit read/write registers. host_be[0] enables bits 7:0 and host_be[1] enables bits 15:8.
- R10: After reset the bank number is 0, bank select reads 0x3300, and every storage slot, counter and flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Byte offset in the window; bit 0 is ignored |
| host_wr | input | 1 | Write strobe, one access per high cycle |
| host_rd | input | 1 | Read strobe; starts side effects of the read |
| host_be | input | 2 | Byte enables for writes |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the current address |
| evt_inc | input | 4 | Event increment pulses for the four counters |

## Verification
The hardest cases are the ones where a counter read and an increment meet at one edge, and the rollover flag with a saturated counter. Reaching them takes a long run of event pulses, up to and past fifteen, followed by a read strobe raised in the same cycle as an event pulse. The bench drives those pulse trains directly and then times a read-with-event task to land on a single edge. It then checks both the value returned and the residue left behind. Soft reset is exercised by first filling storage, then setting the bit and checking that writes, bank changes and events are all refused until it is cleared.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
    localparam int unsigned DW      = 16;
    localparam int unsigned AW      = 4;
    localparam int unsigned BANK_W  = 3;
    localparam int unsigned SLOT_W  = 3;
    localparam int unsigned SLOTS   = 7;
    localparam logic [7:0]  SIG     = 8'h33;
    localparam logic [SLOT_W-1:0] SLOT_SEL    = 3'd7;
    localparam logic [SLOT_W-1:0] SLOT_STATUS = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_RXCTL  = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_CNT    = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_REV    = 3'd5;
    localparam logic [BANK_W-1:0] BANK_REV    = 3'd3;
    localparam int unsigned ROLL_BIT = 12;
    localparam int unsigned SRST_BIT = 15;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [DW-1:0]     rxctl;
        logic              roll;
    } ctl_state_t;

    typedef struct packed {
        logic              sel_hit;
        logic              is_status;
        logic              is_rxctl;
        logic              is_cnt;
        logic              is_rev;
        logic              is_store;
        logic [SLOT_W-1:0] slot;
    } dec_t;
endpackage

// File: rtl/bankwin_dec.sv
module bankwin_dec
    import bankwin_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4
) (
    input  logic [AW-1:0]     addr,
    input  logic [BANK_W-1:0] bank,
    output dec_t              dec
);
    logic bank_ok;
    logic bank0;

    always_comb begin
        bank_ok       = (32'(bank) < NUM_BANKS);
        bank0         = (bank == '0);
        dec.slot      = addr[AW-1:1];
        dec.sel_hit   = (dec.slot == SLOT_SEL);
        dec.is_status = bank0 && (dec.slot == SLOT_STATUS);
        dec.is_rxctl  = bank0 && (dec.slot == SLOT_RXCTL);
        dec.is_cnt    = bank0 && (dec.slot == SLOT_CNT);
        dec.is_rev    = (bank == BANK_REV) && (dec.slot == SLOT_REV);
        dec.is_store  = bank_ok && !dec.sel_hit && !dec.is_status &&
                        !dec.is_rxctl && !dec.is_cnt && !dec.is_rev;
    end
endmodule

// File: rtl/bankwin_evt_cnt.sv
module bankwin_evt_cnt #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             rolled
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = clr ? '0 : cnt_q;
        rolled = 1'b0;
        if (inc) begin
            if (cnt_d == MAXV) rolled = 1'b1;
            else               cnt_d  = cnt_d + 1'b1;
        end
        if (hold) begin
            cnt_d  = '0;
            rolled = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bankwin_store.sv
module bankwin_store
    import bankwin_pkg::*;
#(
    parameter int unsigned ENTRIES = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [ENTRIES-1:0] we,
    input  logic [1:0]         be,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata [ENTRIES]
);
    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
            logic [DW-1:0] val_d, val_q;
            always_comb begin
                val_d = val_q;
                if (we[gi]) begin
                    if (be[0]) val_d[7:0]  = wdata[7:0];
                    if (be[1]) val_d[15:8] = wdata[15:8];
                end
                if (hold) val_d = '0;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= '0;
                else        val_q <= val_d;
            end
            assign rdata[gi] = val_q;
        end
    endgenerate
endmodule

// File: rtl/bankwin_regs.sv
module bankwin_regs
    import bankwin_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_CNT   = 4,
    parameter int unsigned CNT_W     = 4,
    parameter logic [7:0]  REV_CODE  = 8'h91
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_be,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic [NUM_CNT-1:0] evt_inc
);
    localparam int unsigned ENTRIES = NUM_BANKS * SLOTS;
    localparam int unsigned CNT_BITS = NUM_CNT * CNT_W;

    ctl_state_t st_d, st_q;
    dec_t       dec;
    logic       soft_rst_q;
    logic       cnt_read;
    logic [ENTRIES-1:0]  store_we;
    logic [DW-1:0]       store_q [ENTRIES];
    logic [CNT_BITS-1:0] cnt_flat;
    logic [NUM_CNT-1:0]  rolled;
    logic [DW-1:0]       cnt_word;

    assign soft_rst_q = st_q.rxctl[SRST_BIT];

    bankwin_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (host_addr),
        .bank (st_q.bank),
        .dec  (dec)
    );

    bankwin_store #(.ENTRIES(ENTRIES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (soft_rst_q),
        .we    (store_we),
        .be    (host_be),
        .wdata (host_wdata),
        .rdata (store_q)
    );

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CNT; gc++) begin : g_cnt
            bankwin_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .hold   (soft_rst_q),
                .clr    (cnt_read),
                .inc    (evt_inc[gc]),
                .cnt    (cnt_flat[gc*CNT_W +: CNT_W]),
                .rolled (rolled[gc])
            );
        end
    endgenerate

    always_comb begin
        cnt_word = '0;
        cnt_word[CNT_BITS-1:0] = cnt_flat;
    end

    // next-state process
    always_comb begin
        int idx;
        st_d     = st_q;
        idx      = 32'(st_q.bank) * SLOTS + 32'(dec.slot);
        cnt_read = host_rd && dec.is_cnt && !soft_rst_q;
        store_we = '0;

        if (host_wr && dec.is_rxctl) begin
            if (host_be[0]) st_d.rxctl[7:0]  = host_wdata[7:0];
            if (host_be[1]) st_d.rxctl[15:8] = host_wdata[15:8];
        end
        if (host_wr && !soft_rst_q) begin
            if (dec.sel_hit && host_be[0]) st_d.bank = host_wdata[BANK_W-1:0];
            if (dec.is_store && idx < ENTRIES) store_we[idx] = 1'b1;
        end

        if (cnt_read)         st_d.roll = 1'b0;
        else if (|rolled)     st_d.roll = 1'b1;

        if (soft_rst_q) begin
            st_d.bank = '0;
            st_d.roll = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        int ridx;
        ridx       = 32'(st_q.bank) * SLOTS + 32'(dec.slot);
        host_rdata = '0;
        if (dec.sel_hit) begin
            host_rdata[15:8]       = SIG;
            host_rdata[BANK_W-1:0] = st_q.bank;
        end else if (dec.is_rxctl) begin
            host_rdata = st_q.rxctl;
        end else if (dec.is_status) begin
            host_rdata[ROLL_BIT] = st_q.roll;
        end else if (dec.is_cnt) begin
            host_rdata = cnt_word;
        end else if (dec.is_rev) begin
            host_rdata = {SIG, REV_CODE};
        end else if (dec.is_store && ridx < ENTRIES) begin
            host_rdata = store_q[ridx];
        end
    end
endmodule

// File: rtl/bankwin_regs_chk.sv
module bankwin_regs_chk
    import bankwin_pkg::*;
#(
    parameter int unsigned CNT_BITS = 16,
    parameter logic [7:0]  REV_CODE = 8'h91
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       host_addr,
    input logic                host_rd,
    input logic [DW-1:0]       host_rdata,
    input logic [3:0]          evt_inc,
    input logic [BANK_W-1:0]   bank_q,
    input logic                roll_q,
    input logic                soft_rst_q,
    input logic [CNT_BITS-1:0] cnt_flat
);
    logic cnt_rd;
    assign cnt_rd = host_rd && bank_q == '0 && host_addr[3:1] == SLOT_CNT && !soft_rst_q;

    p_sig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr[3:1] == SLOT_SEL |-> host_rdata[15:8] == SIG && host_rdata[7:3] == 5'd0);

    p_rev_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q == BANK_REV && host_addr[3:1] == SLOT_REV) |-> host_rdata == {SIG, REV_CODE});

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && evt_inc == 4'd0) |=> cnt_flat == '0);

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd |=> !roll_q);

    p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_flat[3:0] == 4'hF && !cnt_rd && !soft_rst_q) |=> cnt_flat[3:0] == 4'hF);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_q |=> bank_q == '0 && cnt_flat == '0 && !roll_q);

    p_unimpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q >= 3'd4 && host_addr[3:1] != SLOT_SEL) |-> host_rdata == '0);
endmodule

bind bankwin_regs bankwin_regs_chk #(.CNT_BITS(CNT_BITS), .REV_CODE(REV_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .evt_inc    (evt_inc),
    .bank_q     (st_q.bank),
    .roll_q     (st_q.roll),
    .soft_rst_q (soft_rst_q),
    .cnt_flat   (cnt_flat)
);

// File: tb/bankwin_regs_test.sv
module bankwin_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_be = 2'b11;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [3:0]  evt_inc = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bankwin_regs uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_be(host_be), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .evt_inc(evt_inc)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d, logic [1:0] be = 2'b11);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_be = be; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d, input logic [3:0] ev = 4'd0);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1; evt_inc = ev;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; evt_inc = '0;
    endtask

    task automatic pulse(logic [3:0] m, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); evt_inc = m;
        end
        @(negedge clk); evt_inc = '0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(4'hE, v); check("R10 bank select after reset", v, 16'h3300);
        rd(4'h0, v); check("R10 storage after reset", v, 16'h0000);
        rd(4'h6, v); check("R10 counters after reset", v, 16'h0000);
    endtask

    task automatic t_bank_select;
        logic [15:0] v;
        wr(4'hE, 16'hFFFB);
        rd(4'hE, v); check("R2 masked bank select", v & 16'hFF07, 16'h3303);
        check("R2 full bank select", v, 16'h3303);
        wr(4'hE, 16'h0001);
        rd(4'hE, v); check("R1 bank select from bank 3", v, 16'h3301);
    endtask

    task automatic t_storage;
        logic [15:0] v;
        wr(4'hE, 16'd1); wr(4'h0, 16'hA5A5);
        wr(4'hE, 16'd2); wr(4'h0, 16'h1234);
        wr(4'hE, 16'd1); rd(4'h0, v); check("R9 bank1 storage", v, 16'hA5A5);
        wr(4'h0, 16'hFFFF, 2'b01); rd(4'h0, v); check("R9 low byte enable", v, 16'hA5FF);
        wr(4'hE, 16'd2); rd(4'h0, v); check("R9 bank2 independent", v, 16'h1234);
    endtask

    task automatic t_revision;
        logic [15:0] v;
        wr(4'hE, 16'd3); rd(4'hA, v); check("R3 revision", v, 16'h3391);
        wr(4'hA, 16'h0000); rd(4'hA, v); check("R3 revision after write", v, 16'h3391);
    endtask

    task automatic t_unimpl;
        logic [15:0] v;
        wr(4'hE, 16'd5); wr(4'h0, 16'hBEEF);
        rd(4'h0, v); check("R8 unimplemented bank read", v, 16'h0000);
        rd(4'hE, v); check("R8 bank select in bank 5", v, 16'h3305);
        wr(4'hE, 16'd1); rd(4'h0, v); check("R8 bank1 untouched", v, 16'hA5FF);
    endtask

    task automatic t_counters;
        logic [15:0] v;
        wr(4'hE, 16'd0);
        pulse(4'b0001, 3); pulse(4'b0010, 2); pulse(4'b0100, 1); pulse(4'b1000, 5);
        rd(4'h6, v); check("R4 counter fields", v, 16'h5123);
        rd(4'h6, v); check("R5 counters cleared", v, 16'h0000);
        pulse(4'b0001, 2);
        rd(4'h6, v, 4'b0001); check("R5 read with increment returns", v, 16'h0002);
        rd(4'h6, v); check("R5 increment after clear", v, 16'h0001);
    endtask

    task automatic t_rollover;
        logic [15:0] v;
        pulse(4'b0001, 15);
        rd(4'h2, v); check("R6 no flag at fifteen", v, 16'h0000);
        pulse(4'b0001, 20);
        rd(4'h2, v); check("R6 rollover flag", v, 16'h1000);
        rd(4'h6, v); check("R6 saturated", v, 16'h000F);
        rd(4'h2, v); check("R6 flag cleared by read", v, 16'h0000);
    endtask

    task automatic t_soft_reset;
        logic [15:0] v;
        pulse(4'b0100, 3);
        wr(4'hE, 16'd1);
        wr(4'hE, 16'd0);
        wr(4'h4, 16'h8000);
        wr(4'hE, 16'd1);
        rd(4'hE, v); check("R7 bank held at zero", v, 16'h3300);
        pulse(4'b0001, 4);
        rd(4'h4, v); check("R7 rx control readable", v, 16'h8000);
        wr(4'h4, 16'h0000);
        rd(4'h6, v); check("R7 counters held clear", v, 16'h0000);
        wr(4'hE, 16'd1);
        rd(4'h0, v); check("R7 storage cleared", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bank_select();
        t_storage();
        t_revision();
        t_unimpl();
        t_counters();
        t_rollover();
        t_soft_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule